// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is a binary up-counter built from identical 4-bit slices that chain into a wider counter with no gating between them. Each slice has a synchronous parallel preset, an active-low clear and two count enables with different jobs. The shared enable `en_all` gates counting in every slice at once. The chain enable `en_chain` gates counting and also gates the slice's carry output.

The slices are linked by carry. The carry of each slice feeds the chain enable of the next slice, and `en_all` goes to every slice. The whole word therefore steps as one binary counter, one increment per clock. A build-time parameter chooses how clear acts: at once, without waiting for a clock, or at the next rising edge.

On each rising edge the priority order is:
1. clear (in synchronous mode),
2. load,
3. count,
4. hold.

Top module: `bincnt_chain`

## Requirements
- R1: With CLR_MODE = CLR_SYNC, a low `clr_n` at a rising edge sets the whole count to 0 at that edge. The count does not change before the edge. Clear overrides load and both enables.
- R2: With CLR_MODE = CLR_ASYNC, a low `clr_n` forces the count to 0 at once, without a clock edge. The count stays 0 while `clr_n` is low.
- R3: When clear is inactive and `load_n` is low, the count equals `din` after the next rising edge, whatever the levels of `en_all` and `en_chain`.
- R4: When `clr_n` and `load_n` are high and both `en_all` and `en_chain` are high, each rising edge adds 1 to the count.
- R5: When `clr_n` and `load_n` are high and either enable is low, the count holds its value across the edge.
- R6: Each slice's carry is combinational and equals `en_chain` AND (slice count all ones). The carry is low whenever `en_chain` is low. `carry_out` is driven the same way from the whole word, whatever the level of `en_all`.
- R7: Slice g (lowest slice is g = 0, in `cnt[3:0]`) takes its chain enable from the carry of slice g-1. The full STAGES*WIDTH-bit word therefore increments as one binary number in a single clock, including carries across slice boundaries.
- R8: Counting wraps from all ones to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous per CLR_MODE |
| load_n | input | 1 | Active-low synchronous preset |
| en_all | input | 1 | Count enable shared by all slices |
| en_chain | input | 1 | Count enable of slice 0; also gates the carry output |
| din | input | STAGES*WIDTH (12) | Preset value |
| cnt | output | STAGES*WIDTH (12) | Current count |
| carry_out | output | 1 | High when `en_chain` is high and the count is all ones |

## Verification
On every cycle, assertions check the following:
- the per-slice increment, hold and preset rules;
- the carry gating by the chain enable;
- the clear behaviour of the selected mode;
- the one-clock whole-word increment at the top.

Some behaviour can only be shown by the bench's scenarios, which run both clear modes side by side against a 12-bit reference model. These include:
- the asynchronous clear taking effect between edges while the synchronous variant waits;
- clear winning over load;
- carries crossing slice boundaries;
- the wrap from all ones.

// File: rtl/bincnt_pkg.sv
package bincnt_pkg;
    typedef enum logic {
        CLR_ASYNC = 1'b0,
        CLR_SYNC  = 1'b1
    } clr_mode_e;
endpackage

// File: rtl/bincnt_carry.sv
module bincnt_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] value,
    input  logic             en_chain,
    output logic             carry
);
    // R6: carry needs the chain enable and a terminal count
    always_comb begin
        carry = en_chain & (&value);
    end
endmodule

// File: rtl/bincnt_stage.sv
module bincnt_stage
    import bincnt_pkg::*;
#(
    parameter int        WIDTH    = 4,
    parameter clr_mode_e CLR_MODE = CLR_ASYNC
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_all,
    input  logic             en_chain,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             carry
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] value;
    } slice_state_t;

    slice_state_t st_d, st_q;
    logic         sync_clr;

    assign sync_clr = (CLR_MODE == CLR_SYNC) && !clr_n;

    always_comb begin
        st_d = st_q;
        if (sync_clr) begin
            st_d.value = '0;
        end else if (!load_n) begin
            st_d.value = din;
        end else if (en_all && en_chain) begin
            st_d.value = st_q.value + ONE;
        end
    end

    generate
        if (CLR_MODE == CLR_ASYNC) begin : g_async_clr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
            // R2: count is zero while clear is held
            a_r2_async_clear: assert property (@(posedge clk)
                !clr_n |-> (q == '0));
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end
            // R1: clear seen at an edge leaves zero after it
            a_r1_sync_clear: assert property (@(posedge clk)
                !clr_n |=> (q == '0));
        end
    endgenerate

    assign q = st_q.value;

    bincnt_carry #(.WIDTH(WIDTH)) u_carry (
        .value   (st_q.value),
        .en_chain(en_chain),
        .carry   (carry)
    );

    // R3: preset wins over the enables
    a_r3_load: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (q == $past(din)));
    // R4 / R8: increment by one, wrapping modulo 2**WIDTH
    a_r4_count: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_all && en_chain) |=> (q == $past(q) + ONE));
    // R5: hold when an enable is low
    a_r5_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_all && en_chain)) |=> $stable(q));
    // R6: carry stays low without the chain enable
    a_r6_carry_gated: assert property (@(posedge clk) disable iff (!clr_n)
        !en_chain |-> !carry);
    // R6: carry rises at terminal count with the chain enable
    a_r6_carry_tc: assert property (@(posedge clk) disable iff (!clr_n)
        (en_chain && (&q)) |-> carry);
endmodule

// File: rtl/bincnt_chain.sv
module bincnt_chain
    import bincnt_pkg::*;
#(
    parameter int        WIDTH    = 4,
    parameter int        STAGES   = 3,
    parameter clr_mode_e CLR_MODE = CLR_ASYNC
) (
    input  logic                      clk,
    input  logic                      clr_n,
    input  logic                      load_n,
    input  logic                      en_all,
    input  logic                      en_chain,
    input  logic [STAGES*WIDTH-1:0]   din,
    output logic [STAGES*WIDTH-1:0]   cnt,
    output logic                      carry_out
);
    localparam int TOTAL = STAGES * WIDTH;
    localparam logic [TOTAL-1:0] ONE_W = TOTAL'(1);

    logic [STAGES-1:0] t_in;
    logic [STAGES-1:0] c_out;

    assign t_in[0] = en_chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_slice
            if (g > 0) begin : g_link
                // R7: previous carry drives this slice's chain enable
                assign t_in[g] = c_out[g-1];
            end
            bincnt_stage #(
                .WIDTH   (WIDTH),
                .CLR_MODE(CLR_MODE)
            ) u_stage (
                .clk     (clk),
                .clr_n   (clr_n),
                .load_n  (load_n),
                .en_all  (en_all),
                .en_chain(t_in[g]),
                .din     (din[g*WIDTH +: WIDTH]),
                .q       (cnt[g*WIDTH +: WIDTH]),
                .carry   (c_out[g])
            );
        end
    endgenerate

    assign carry_out = c_out[STAGES-1];

    // R7: whole word steps by one per enabled clock
    a_r7_word_step: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_all && en_chain) |=> (cnt == $past(cnt) + ONE_W));
    // R6 / R7: top carry reflects the full word at terminal count
    a_r7_top_carry: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out == (en_chain && (&cnt)));
endmodule

// File: tb/tb_bincnt_chain.sv
module tb_bincnt_chain;
    import bincnt_pkg::*;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         load_n = 1'b1;
    logic         en_all = 1'b0;
    logic         en_chain = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] cnt_a, cnt_s;
    logic         co_a, co_s;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] model = '0;
    logic [W-1:0] exp_cnt_q[$];
    logic         exp_co_q[$];
    string        tag_q[$];

    always #2 clk = ~clk;  // 250 MHz

    bincnt_chain #(.WIDTH(4), .STAGES(3), .CLR_MODE(CLR_ASYNC)) dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_all(en_all),
        .en_chain(en_chain), .din(din), .cnt(cnt_a), .carry_out(co_a));

    bincnt_chain #(.WIDTH(4), .STAGES(3), .CLR_MODE(CLR_SYNC)) dut_sync (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_all(en_all),
        .en_chain(en_chain), .din(din), .cnt(cnt_s), .carry_out(co_s));

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and queue the expected result
    task automatic step(input logic c, input logic l, input logic ea,
                        input logic ec, input logic [W-1:0] d);
        logic [W-1:0] prev;
        string tag;
        @(negedge clk);
        prev = model;
        clr_n = c; load_n = l; en_all = ea; en_chain = ec; din = d;
        if (!c) begin
            model = '0; tag = "R1/R2 clear";
        end else if (!l) begin
            model = d; tag = "R3 load";
        end else if (ea && ec) begin
            model = model + 12'd1; tag = "R4/R7/R8 count";
        end else begin
            tag = "R5 hold";
        end
        exp_cnt_q.push_back(model);
        exp_co_q.push_back(ec & (&model));
        tag_q.push_back(tag);
        if (!c) begin
            #1;
            check("R2 async clear immediate", cnt_a, '0);
            check("R1 sync clear waits for edge", cnt_s, prev);
        end
    endtask

    // monitor: compare after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_cnt_q.size() > 0) begin
            logic [W-1:0] e;
            logic         ec;
            string        t;
            e = exp_cnt_q.pop_front();
            ec = exp_co_q.pop_front();
            t = tag_q.pop_front();
            check({t, " async"}, cnt_a, e);
            check({t, " sync"}, cnt_s, e);
            check("R6 carry async", {11'd0, co_a}, {11'd0, ec});
            check("R6 carry sync", {11'd0, co_s}, {11'd0, ec});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // reset state, R1 R2
        step(0, 1, 1, 1, 12'h000);
        step(0, 1, 1, 1, 12'h000);
        // R3: load with both enables low
        step(1, 0, 0, 0, 12'hFFD);
        // R4 R8: count through terminal count and wrap, R6 carry high at FFF
        step(1, 1, 1, 1, 12'h000);
        step(1, 1, 1, 1, 12'h000);
        step(1, 1, 1, 1, 12'h000);
        // R3: load wins over active enables
        step(1, 0, 1, 1, 12'h0FF);
        // R5: hold with chain enable low, then shared enable low
        step(1, 1, 1, 0, 12'h000);
        step(1, 1, 0, 1, 12'h000);
        // R6: terminal count with chain enable low -> carry low
        step(1, 0, 0, 0, 12'hFFF);
        step(1, 1, 1, 0, 12'h000);
        // R6: shared enable low does not suppress carry
        step(1, 1, 0, 1, 12'h000);
        // R1/R2: clear wins over load
        step(0, 0, 1, 1, 12'hABC);
        // R7: carry across slice boundaries
        step(1, 0, 1, 1, 12'h00F);
        step(1, 1, 1, 1, 12'h000);
        step(1, 0, 1, 1, 12'h0FF);
        step(1, 1, 1, 1, 12'h000);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 40) != 0, ($urandom % 10) != 0,
                 ($urandom % 4) != 0, ($urandom % 4) != 0,
                 12'($urandom));
        end
        // long run through a full wrap of the word, R8
        step(1, 0, 1, 1, 12'hF00);
        for (int i = 0; i < 300; i++) step(1, 1, 1, 1, 12'h000);
        @(negedge clk);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule